// File: doc/BRIEF.md
# Command-Mode Page Load Sequencer

This block produces the block and page address for the simplified, command-driven page load path of a flash device. It holds a current block and a current page, picks the starting point of a load run (block 0 page 0 after boot, or whatever the register path last wrote), and moves to the next page on every further load command. Page advance wraps inside the current block and never changes the block.

Each accepted load raises a one-cycle request that carries the address and a buffer index that is always zero. Only one load may be outstanding at a time. A load strobe that arrives before the previous load-done handshake is refused. A program strobe is always refused, because programming is not offered on this path. Array access and buffer contents belong to other blocks.

Top module: `cmd_load_seq`

## Requirements
- R1: After reset or a boot-done pulse, the next accepted load targets block 0, page 0.
- R2: A block-address write or a page-address write from the register path sets that field of the current address. The next accepted load uses the written address exactly, with no advance.
- R3: Every accepted load after the first one of a run targets the page one above the previous load, in the same block.
- R4: The page after the last page of a block (page 63 with the default 6-bit page field) is page 0 of the same block. The block field never changes through page advance.
- R5: `ld_buf_o` is 0 on every load request.
- R6: A program strobe makes `cmd_rej_o` high in the following cycle. It raises no load request and leaves the address unchanged.
- R7: A load strobe that arrives while a load is outstanding (accepted, with no `load_done_i` seen since) is refused. `cmd_rej_o` goes high in the following cycle, no request is raised, and the address is unchanged. `load_done_i` ends the outstanding state at the clock edge where it is sampled.
- R8: An accepted load raises `ld_req_o` for exactly one cycle, in the cycle after the strobe. `ld_blk_o`/`ld_page_o` present the loaded address in that cycle and hold it until the next change.
- R9: During and right after reset, `ld_req_o` and `cmd_rej_o` are low and the address is block 0, page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_done_i | input | 1 | Boot completion pulse; restarts the run at block 0 page 0 |
| reg_blk_wr_i | input | 1 | Register-path block address write strobe |
| reg_blk_i | input | BLK_W | Written block address |
| reg_page_wr_i | input | 1 | Register-path page address write strobe |
| reg_page_i | input | PAGE_W | Written page address |
| cmd_load_i | input | 1 | Command-mode load strobe |
| cmd_prog_i | input | 1 | Command-mode program strobe (always refused) |
| load_done_i | input | 1 | Completion handshake for the outstanding load |
| ld_req_o | output | 1 | One-cycle load request |
| ld_blk_o | output | BLK_W | Current block address |
| ld_page_o | output | PAGE_W | Current page address |
| ld_buf_o | output | BUF_W | Target buffer index (always 0) |
| cmd_rej_o | output | 1 | One-cycle refused-command flag |

## Verification
Every result is registered, so the request, the refusal flag and the new address all appear one clock after the strobe that causes them. The bench drives each strobe on a falling edge. It compares all outputs at the next falling edge, after exactly one rising edge, against a bench model updated once per step. Directed steps cover the boot origin, a register seed followed by a run that crosses the wrap point, and loads refused during an outstanding load.

// File: rtl/cls_pkg.sv
// Shared parameters and helpers for the command-mode load sequencer.
// Assumes: page counts are a power of two, so page wrap is natural overflow.
package cls_pkg;
    localparam int DEF_BLK_W  = 10;
    localparam int DEF_PAGE_W = 6;
    localparam int DEF_BUF_W  = 1;

    // Cause of a refused command, kept for readability of the controller.
    typedef enum logic [1:0] {
        REJ_NONE = 2'd0,
        REJ_PROG = 2'd1,
        REJ_BUSY = 2'd2
    } rej_cause_e;
endpackage

// File: rtl/cls_addr_track.sv
// Address tracker: holds the current block/page and a "fresh" flag telling
// whether the next accepted load must reuse the seeded address as-is.
// Assumes: boot beats register writes, which beat load advance in one cycle.
module cls_addr_track #(
    parameter int BLK_W  = cls_pkg::DEF_BLK_W,
    parameter int PAGE_W = cls_pkg::DEF_PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_i,
    input  logic              blk_wr_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              page_wr_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              adv_i,
    output logic [BLK_W-1:0]  blk_o,
    output logic [PAGE_W-1:0] page_o
);
    localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);

    logic              fresh_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PAGE_W-1:0] page_q;

    // Update block, page and fresh flag by priority: boot, seed, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q   <= '0;
            page_q  <= '0;
            fresh_q <= 1'b1;
        end else if (boot_i) begin
            blk_q   <= '0;
            page_q  <= '0;
            fresh_q <= 1'b1;
        end else if (blk_wr_i || page_wr_i) begin
            if (blk_wr_i)  blk_q  <= blk_i;
            if (page_wr_i) page_q <= page_i;
            fresh_q <= 1'b1;
        end else if (adv_i) begin
            if (!fresh_q) page_q <= page_q + PAGE_ONE;
            fresh_q <= 1'b0;
        end
    end

    assign blk_o  = blk_q;
    assign page_o = page_q;

    // R1: boot returns the address to the origin.
    p_boot_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        boot_i |=> (blk_q == '0 && page_q == '0));

    // R4: advance never alters the block field.
    p_blk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_i && !blk_wr_i) |=> $stable(blk_q));

    // R3: page only moves by one modulo the block size when advancing.
    p_page_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_i && !blk_wr_i && !page_wr_i && adv_i && !fresh_q)
            |=> page_q == $past(page_q) + PAGE_ONE);

    // R2: a seeded address is used once without advance.
    p_seed_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_i && !blk_wr_i && !page_wr_i && adv_i && fresh_q) |=> $stable(page_q));
endmodule

// File: rtl/cls_load_ctrl.sv
// Load controller: accepts a load only when nothing is outstanding, issues a
// one-cycle request, and flags program strobes and busy loads as refused.
// Assumes: load_done_i arrives only for an outstanding load.
module cls_load_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic prog_i,
    input  logic done_i,
    output logic accept_o,
    output logic req_o,
    output logic rej_o
);
    import cls_pkg::*;

    logic       busy_q;
    logic       req_q;
    logic       rej_q;
    rej_cause_e cause;

    assign accept_o = load_i && !busy_q;

    // Classify this cycle's strobes into a refusal cause.
    always_comb begin
        cause = REJ_NONE;
        if (prog_i)                cause = REJ_PROG;
        else if (load_i && busy_q) cause = REJ_BUSY;
    end

    // Track the outstanding load: set on accept, clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (accept_o) busy_q <= 1'b1;
        else if (done_i)   busy_q <= 1'b0;
    end

    // Register the request and refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            req_q <= accept_o;
            rej_q <= (cause != REJ_NONE);
        end
    end

    assign req_o = req_q;
    assign rej_o = rej_q;

    // R6: program strobe is always refused.
    p_prog_rej_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> rej_q);

    // R7: no request while a load is outstanding.
    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && load_i) |=> (!req_q && rej_q));

    // R8: request lasts a single cycle.
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
endmodule

// File: rtl/cmd_load_seq.sv
// Top of the command-mode page load sequencer. Joins the address tracker and
// the load controller; the buffer index is fixed at zero for this path.
// Assumes: strobes are single-cycle and synchronous to clk.
module cmd_load_seq #(
    parameter int BLK_W  = cls_pkg::DEF_BLK_W,
    parameter int PAGE_W = cls_pkg::DEF_PAGE_W,
    parameter int BUF_W  = cls_pkg::DEF_BUF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_done_i,
    input  logic              reg_blk_wr_i,
    input  logic [BLK_W-1:0]  reg_blk_i,
    input  logic              reg_page_wr_i,
    input  logic [PAGE_W-1:0] reg_page_i,
    input  logic              cmd_load_i,
    input  logic              cmd_prog_i,
    input  logic              load_done_i,
    output logic              ld_req_o,
    output logic [BLK_W-1:0]  ld_blk_o,
    output logic [PAGE_W-1:0] ld_page_o,
    output logic [BUF_W-1:0]  ld_buf_o,
    output logic              cmd_rej_o
);
    logic accept;

    cls_load_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cmd_load_i),
        .prog_i   (cmd_prog_i),
        .done_i   (load_done_i),
        .accept_o (accept),
        .req_o    (ld_req_o),
        .rej_o    (cmd_rej_o)
    );

    cls_addr_track #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_i    (boot_done_i),
        .blk_wr_i  (reg_blk_wr_i),
        .blk_i     (reg_blk_i),
        .page_wr_i (reg_page_wr_i),
        .page_i    (reg_page_i),
        .adv_i     (accept),
        .blk_o     (ld_blk_o),
        .page_o    (ld_page_o)
    );

    // Every command-mode load goes to buffer zero.
    assign ld_buf_o = '0;

    // R9: nothing is requested or refused in the cycle after reset.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!ld_req_o && !cmd_rej_o && ld_blk_o == '0 && ld_page_o == '0));
endmodule

// File: tb/tb_cmd_load_seq.sv
module tb_cmd_load_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W  = 10;
    localparam int PAGE_W = 6;
    localparam int BUF_W  = 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              boot_done_i, reg_blk_wr_i, reg_page_wr_i;
    logic [BLK_W-1:0]  reg_blk_i;
    logic [PAGE_W-1:0] reg_page_i;
    logic              cmd_load_i, cmd_prog_i, load_done_i;
    logic              ld_req_o, cmd_rej_o;
    logic [BLK_W-1:0]  ld_blk_o;
    logic [PAGE_W-1:0] ld_page_o;
    logic [BUF_W-1:0]  ld_buf_o;

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements.
    logic [BLK_W-1:0]  m_blk;
    logic [PAGE_W-1:0] m_page;
    logic              m_fresh, m_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_load_seq #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .BUF_W(BUF_W)) dut (.*);

    function automatic logic [PAGE_W-1:0] next_page(input logic [PAGE_W-1:0] p);
        return (p == PAGE_W'((1 << PAGE_W) - 1)) ? '0 : p + PAGE_W'(1);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        boot_done_i = 0; reg_blk_wr_i = 0; reg_page_wr_i = 0;
        reg_blk_i = '0; reg_page_i = '0;
        cmd_load_i = 0; cmd_prog_i = 0; load_done_i = 0;
    endtask

    // One step: drive at falling edge, compare one rising edge later.
    task automatic step(input logic boot, input logic bw, input logic [BLK_W-1:0] bv,
                        input logic pw, input logic [PAGE_W-1:0] pv,
                        input logic ld, input logic pg, input logic dn, input string tag);
        logic exp_req, exp_rej;
        boot_done_i = boot; reg_blk_wr_i = bw; reg_blk_i = bv;
        reg_page_wr_i = pw; reg_page_i = pv;
        cmd_load_i = ld; cmd_prog_i = pg; load_done_i = dn;
        exp_req = ld && !m_busy;
        exp_rej = pg || (ld && m_busy);
        if (boot) begin
            m_blk = '0; m_page = '0; m_fresh = 1;
        end else if (bw || pw) begin
            if (bw) m_blk = bv;
            if (pw) m_page = pv;
            m_fresh = 1;
        end else if (exp_req) begin
            if (!m_fresh) m_page = next_page(m_page);
            m_fresh = 0;
        end
        if (exp_req) m_busy = 1;
        else if (dn) m_busy = 0;
        @(negedge clk);
        idle_inputs();
        check({tag, " R8 req"}, ld_req_o, exp_req);
        check({tag, " R6/R7 rej"}, cmd_rej_o, exp_rej);
        check({tag, " blk"}, ld_blk_o, m_blk);
        check({tag, " page"}, ld_page_o, m_page);
        if (ld_req_o) check("R5 buf", ld_buf_o, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        m_blk = '0; m_page = '0; m_fresh = 1; m_busy = 0;
        repeat (3) @(negedge clk);
        check("R9 req", ld_req_o, 0);
        check("R9 rej", cmd_rej_o, 0);
        check("R9 blk", ld_blk_o, 0);
        check("R9 page", ld_page_o, 0);
        rst_n = 1;

        // R1: first load after boot goes to origin.
        step(1, 0, '0, 0, '0, 0, 0, 0, "R1 boot");
        step(0, 0, '0, 0, '0, 1, 0, 0, "R1 first");
        check("R1 page0", ld_page_o, 0);
        step(0, 0, '0, 0, '0, 0, 0, 1, "R7 done");
        step(0, 0, '0, 0, '0, 1, 0, 0, "R3 next");
        check("R3 page1", ld_page_o, 1);
        // R7: load while outstanding is refused.
        step(0, 0, '0, 0, '0, 1, 0, 0, "R7 busy");
        step(0, 0, '0, 0, '0, 1, 0, 1, "R7 busy+done");
        step(0, 0, '0, 0, '0, 1, 0, 0, "R7 after");
        check("R7 page2", ld_page_o, 2);
        step(0, 0, '0, 0, '0, 0, 0, 1, "R7 done");
        // R2/R4: seed near end of block and wrap.
        step(0, 1, 10'd517, 1, 6'd62, 0, 0, 0, "R2 seed");
        step(0, 0, '0, 0, '0, 1, 0, 0, "R2 use");
        check("R2 page62", ld_page_o, 62);
        check("R2 blk517", ld_blk_o, 517);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, '0, 0, '0, 0, 0, 1, "R4 done");
            step(0, 0, '0, 0, '0, 1, 0, 0, "R4 wrap");
        end
        check("R4 page1", ld_page_o, 1);
        check("R4 blk", ld_blk_o, 517);
        // R6: program refused.
        step(0, 0, '0, 0, '0, 0, 1, 1, "R6 prog");

        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 99);
            logic dn = ($urandom_range(0, 2) == 0);
            if (sel < 3)       step(1, 0, '0, 0, '0, 0, 0, dn, "R1 rnd");
            else if (sel < 8)  step(0, 1, BLK_W'($urandom), 0, '0, 0, 0, dn, "R2 rnd");
            else if (sel < 13) step(0, 0, '0, 1, PAGE_W'($urandom), 0, 0, dn, "R2 rnd");
            else if (sel < 18) step(0, 0, '0, 0, '0, 0, 1, dn, "R6 rnd");
            else if (sel < 70) step(0, 0, '0, 0, '0, 1, 0, dn, "R3 rnd");
            else               step(0, 0, '0, 0, '0, 0, 0, dn, "R7 rnd");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule